// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Register Block

This block sits beside a SECDED-protected DRAM controller and turns the decoder's error pulses into state that software can read. The ECC decoder raises a one-cycle pulse for each correctable or uncorrectable event. With the pulse it presents the failing address, the 64-bit data word, the 8-bit syndrome and the ID of the requester. The block keeps one capture set for each class of error. The first event of a class fills that class's log and sets its flag. A further event of the same class, arriving before software acknowledges the first, only sets an overflow flag. A level interrupt stays high while any flag is set. Software clears flags by writing ones to an acknowledge register.

The block also holds the ECC option register. It carries the ECC mode field, a one-shot injection arm bit and an 8-bit mask. While the arm bit is set, the next write request to memory has the mask applied as an XOR onto its check bits. The arm bit then drops by itself. Software reaches every register through a simple word-wide port: a write strobe with an offset, and a read data bus that is decoded combinationally from the offset.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, every flag, log field, the arm bit and the mask read as zero, `irq` is low, and the mode field reads the `MODE_RST` parameter value (default 1).
- R2: A correctable pulse while the correctable flag is clear captures the event and sets status bit 3 (status at offset 0x180). The address appears at 0x140, the syndrome in bits 15:8 of the word at 0x144 (other bits zero), data bits 31:0 at 0x148, data bits 63:32 at 0x14C, and the requester ID at 0x428.
- R3: An uncorrectable pulse while the uncorrectable flag is clear captures the event in the same layout and sets status bit 5. The address is at 0x130, the syndrome word at 0x134, the data at 0x138 (low) and 0x13C (high), and the ID at 0x424.
- R4: A pulse of a class whose flag is already set sets that class's overflow bit (bit 4 for correctable, bit 6 for uncorrectable) and leaves the captured log unchanged.
- R5: A write to offset 0x184 clears exactly the status bits that are one in the written value and leaves every other status bit as it was.
- R6: `irq` is high whenever any of status bits 3 to 6 is set, and it falls only once all of them have been cleared.
- R7: When a pulse and an acknowledge of the same class's flag fall in the same cycle, the pulse wins and the flag stays set. If the flag was already set, the overflow bit is also set and the log is kept.
- R8: The two classes are independent. A pulse of one class changes neither the log nor the bits of the other class, and pulses of both classes in one cycle fill both logs.
- R9: The option register at offset 0x128 holds the mode in bits 1:0, the arm bit in bit 8 and the mask in bits 23:16. Other bits read as zero, and a write replaces all three fields.
- R10: While the arm bit is set, `chk_xor` equals the mask in a cycle with `wr_req` high. In the next cycle the arm bit is clear, and the mode and mask are unchanged. When the arm bit is clear, `chk_xor` is zero.
- R11: `ecc_active` is high exactly when the mode field is 1 or 3. Modes 0 and 2 mean that ECC is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (12) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ce_evt | input | 1 | Correctable error pulse |
| ue_evt | input | 1 | Uncorrectable error pulse |
| evt_addr | input | ADDR_W (32) | Failing address |
| evt_data | input | DATA_W (64) | Failing data word |
| evt_synd | input | SYND_W (8) | Syndrome of the failing word |
| evt_id | input | ID_W (16) | Requester ID |
| wr_req | input | 1 | Memory write request being encoded this cycle |
| chk_xor | output | CHK_W (8) | Mask to XOR onto this write's check bits |
| ecc_active | output | 1 | ECC is enabled by the mode field |
| irq | output | 1 | Level interrupt |

## Verification
The bench sends a second error of a class before the first is acknowledged. A block that let it overwrite the log would report the wrong address to software, and one that missed it would drop the overflow bit. The bench acknowledges one bit out of two. Clearing too wide a mask would lose the overflow flag and drop `irq` early. It also puts an error pulse in the same cycle as its acknowledge, where letting the clear win would silently lose an error. For injection, the bench checks that the mask reaches exactly one write. A disarm that was late or never happened would corrupt a second write, and a disarm that also wrote the register would disturb the mode field.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
   localparam int REG_DW = 32;
   localparam int REG_AW = 12;

   // register offsets
   localparam logic [REG_AW-1:0] OFS_OPT     = 12'h128;
   localparam logic [REG_AW-1:0] OFS_UE_ADDR = 12'h130;
   localparam logic [REG_AW-1:0] OFS_UE_STAT = 12'h134;
   localparam logic [REG_AW-1:0] OFS_UE_DLO  = 12'h138;
   localparam logic [REG_AW-1:0] OFS_UE_DHI  = 12'h13C;
   localparam logic [REG_AW-1:0] OFS_CE_ADDR = 12'h140;
   localparam logic [REG_AW-1:0] OFS_CE_STAT = 12'h144;
   localparam logic [REG_AW-1:0] OFS_CE_DLO  = 12'h148;
   localparam logic [REG_AW-1:0] OFS_CE_DHI  = 12'h14C;
   localparam logic [REG_AW-1:0] OFS_STATUS  = 12'h180;
   localparam logic [REG_AW-1:0] OFS_ACK     = 12'h184;
   localparam logic [REG_AW-1:0] OFS_UE_ID   = 12'h424;
   localparam logic [REG_AW-1:0] OFS_CE_ID   = 12'h428;

   // error classes, index into capture arrays
   localparam int NCLS   = 2;
   localparam int CLS_CE = 0;
   localparam int CLS_UE = 1;

   // status bit of the first flag of class 0; each class takes two bits
   localparam int ST_BASE = 3;

   // option register field positions
   localparam int OPT_ARM_BIT = 8;
   localparam int OPT_MSK_LSB = 16;
   localparam int OPT_MSK_W   = 8;
   localparam int STAT_SYN_LSB = 8;

   function automatic int single_bit(input int cls);
      return ST_BASE + 2 * cls;
   endfunction

   function automatic int double_bit(input int cls);
      return ST_BASE + 2 * cls + 1;
   endfunction
endpackage

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int SYND_W = 8,
   parameter int ID_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt,
   input  logic              ack_single,
   input  logic              ack_double,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   input  logic [SYND_W-1:0] in_synd,
   input  logic [ID_W-1:0]   in_id,
   output logic              single_q,
   output logic              double_q,
   output logic [ADDR_W-1:0] log_addr,
   output logic [DATA_W-1:0] log_data,
   output logic [SYND_W-1:0] log_synd,
   output logic [ID_W-1:0]   log_id
);
   logic load;
   assign load = evt & ~single_q;

   // flags: a new event beats a same-cycle acknowledge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         single_q <= 1'b0;
         double_q <= 1'b0;
      end else begin
         single_q <= evt | (single_q & ~ack_single);
         double_q <= (evt & single_q) | (double_q & ~ack_double);
      end
   end

   // log is written only by the first event of a burst
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         log_addr <= '0;
         log_data <= '0;
         log_synd <= '0;
         log_id   <= '0;
      end else if (load) begin
         log_addr <= in_addr;
         log_data <= in_data;
         log_synd <= in_synd;
         log_id   <= in_id;
      end
   end
endmodule

// File: rtl/ecc_inject_ctl.sv
module ecc_inject_ctl #(
   parameter int         CHK_W    = 8,
   parameter logic [1:0] MODE_RST = 2'd1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             opt_we,
   input  logic [1:0]       wr_mode,
   input  logic             wr_arm,
   input  logic [CHK_W-1:0] wr_mask,
   input  logic             wr_req,
   output logic [1:0]       mode_q,
   output logic             arm_q,
   output logic [CHK_W-1:0] mask_q,
   output logic [CHK_W-1:0] chk_xor,
   output logic             ecc_active
);
   logic fire;
   assign fire = arm_q & wr_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_RST;
         arm_q  <= 1'b0;
         mask_q <= '0;
      end else if (opt_we) begin
         mode_q <= wr_mode;
         arm_q  <= wr_arm;
         mask_q <= wr_mask;
      end else if (fire) begin
         arm_q  <= 1'b0;
      end
   end

   assign chk_xor    = fire ? mask_q : '0;
   assign ecc_active = (mode_q == 2'd1) || (mode_q == 2'd3);
endmodule

// File: rtl/ecc_reg_read.sv
module ecc_reg_read
   import ecc_log_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int SYND_W = 8,
   parameter int ID_W   = 16,
   parameter int CHK_W  = 8
) (
   input  logic [REG_AW-1:0] addr,
   input  logic [1:0]        mode,
   input  logic              arm,
   input  logic [CHK_W-1:0]  mask,
   input  logic [REG_DW-1:0] status,
   input  logic [ADDR_W-1:0] ce_addr,
   input  logic [DATA_W-1:0] ce_data,
   input  logic [SYND_W-1:0] ce_synd,
   input  logic [ID_W-1:0]   ce_id,
   input  logic [ADDR_W-1:0] ue_addr,
   input  logic [DATA_W-1:0] ue_data,
   input  logic [SYND_W-1:0] ue_synd,
   input  logic [ID_W-1:0]   ue_id,
   output logic [REG_DW-1:0] rdata
);
   logic [REG_DW-1:0] opt_word, ce_stat_w, ue_stat_w;

   always_comb begin
      opt_word = '0;
      opt_word[1:0] = mode;
      opt_word[OPT_ARM_BIT] = arm;
      opt_word[OPT_MSK_LSB +: CHK_W] = mask;
      ce_stat_w = '0;
      ce_stat_w[STAT_SYN_LSB +: SYND_W] = ce_synd;
      ue_stat_w = '0;
      ue_stat_w[STAT_SYN_LSB +: SYND_W] = ue_synd;
   end

   always_comb begin
      unique case (addr)
         OFS_OPT:     rdata = opt_word;
         OFS_STATUS:  rdata = status;
         OFS_CE_ADDR: rdata = REG_DW'(ce_addr);
         OFS_CE_STAT: rdata = ce_stat_w;
         OFS_CE_DLO:  rdata = ce_data[REG_DW-1:0];
         OFS_CE_DHI:  rdata = ce_data[DATA_W-1:REG_DW];
         OFS_CE_ID:   rdata = REG_DW'(ce_id);
         OFS_UE_ADDR: rdata = REG_DW'(ue_addr);
         OFS_UE_STAT: rdata = ue_stat_w;
         OFS_UE_DLO:  rdata = ue_data[REG_DW-1:0];
         OFS_UE_DHI:  rdata = ue_data[DATA_W-1:REG_DW];
         OFS_UE_ID:   rdata = REG_DW'(ue_id);
         default:     rdata = '0;
      endcase
   end
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
   import ecc_log_pkg::*;
#(
   parameter int         ADDR_W   = 32,
   parameter int         DATA_W   = 64,
   parameter int         SYND_W   = 8,
   parameter int         ID_W     = 16,
   parameter int         CHK_W    = 8,
   parameter logic [1:0] MODE_RST = 2'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic              ce_evt,
   input  logic              ue_evt,
   input  logic [ADDR_W-1:0] evt_addr,
   input  logic [DATA_W-1:0] evt_data,
   input  logic [SYND_W-1:0] evt_synd,
   input  logic [ID_W-1:0]   evt_id,
   input  logic              wr_req,
   output logic [CHK_W-1:0]  chk_xor,
   output logic              ecc_active,
   output logic              irq
);
   // elaboration-time parameter checks
   if (DATA_W != 2 * REG_DW) begin : g_bad_data
      $error("DATA_W must be two register words");
   end
   if (ADDR_W < 1 || ADDR_W > REG_DW) begin : g_bad_addr
      $error("ADDR_W must fit one register word");
   end
   if (ID_W < 1 || ID_W > REG_DW) begin : g_bad_id
      $error("ID_W must fit one register word");
   end
   if (SYND_W < 1 || SYND_W > 8) begin : g_bad_synd
      $error("SYND_W must fit the 8-bit syndrome field");
   end
   if (CHK_W < 1 || CHK_W > OPT_MSK_W) begin : g_bad_chk
      $error("CHK_W must fit the 8-bit mask field");
   end

   logic opt_we, ack_we;
   assign opt_we = reg_wen && (reg_addr == OFS_OPT);
   assign ack_we = reg_wen && (reg_addr == OFS_ACK);

   logic [NCLS-1:0]   cls_evt, cls_single, cls_double;
   logic [ADDR_W-1:0] cls_addr [NCLS];
   logic [DATA_W-1:0] cls_data [NCLS];
   logic [SYND_W-1:0] cls_synd [NCLS];
   logic [ID_W-1:0]   cls_id   [NCLS];

   assign cls_evt[CLS_CE] = ce_evt;
   assign cls_evt[CLS_UE] = ue_evt;

   for (genvar g = 0; g < NCLS; g++) begin : g_cls
      localparam int SB = single_bit(g);
      localparam int DB = double_bit(g);
      ecc_err_capture #(
         .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYND_W(SYND_W), .ID_W(ID_W)
      ) u_cap (
         .clk       (clk),
         .rst_n     (rst_n),
         .evt       (cls_evt[g]),
         .ack_single(ack_we & reg_wdata[SB]),
         .ack_double(ack_we & reg_wdata[DB]),
         .in_addr   (evt_addr),
         .in_data   (evt_data),
         .in_synd   (evt_synd),
         .in_id     (evt_id),
         .single_q  (cls_single[g]),
         .double_q  (cls_double[g]),
         .log_addr  (cls_addr[g]),
         .log_data  (cls_data[g]),
         .log_synd  (cls_synd[g]),
         .log_id    (cls_id[g])
      );
   end

   logic [REG_DW-1:0] status;
   always_comb begin
      status = '0;
      for (int c = 0; c < NCLS; c++) begin
         status[single_bit(c)] = cls_single[c];
         status[double_bit(c)] = cls_double[c];
      end
   end
   assign irq = |status;

   logic [1:0]       opt_mode;
   logic             opt_arm;
   logic [CHK_W-1:0] opt_mask;

   ecc_inject_ctl #(.CHK_W(CHK_W), .MODE_RST(MODE_RST)) u_inj (
      .clk       (clk),
      .rst_n     (rst_n),
      .opt_we    (opt_we),
      .wr_mode   (reg_wdata[1:0]),
      .wr_arm    (reg_wdata[OPT_ARM_BIT]),
      .wr_mask   (reg_wdata[OPT_MSK_LSB +: CHK_W]),
      .wr_req    (wr_req),
      .mode_q    (opt_mode),
      .arm_q     (opt_arm),
      .mask_q    (opt_mask),
      .chk_xor   (chk_xor),
      .ecc_active(ecc_active)
   );

   ecc_reg_read #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYND_W(SYND_W), .ID_W(ID_W), .CHK_W(CHK_W)
   ) u_rd (
      .addr   (reg_addr),
      .mode   (opt_mode),
      .arm    (opt_arm),
      .mask   (opt_mask),
      .status (status),
      .ce_addr(cls_addr[CLS_CE]),
      .ce_data(cls_data[CLS_CE]),
      .ce_synd(cls_synd[CLS_CE]),
      .ce_id  (cls_id[CLS_CE]),
      .ue_addr(cls_addr[CLS_UE]),
      .ue_data(cls_data[CLS_UE]),
      .ue_synd(cls_synd[CLS_UE]),
      .ue_id  (cls_id[CLS_UE]),
      .rdata  (reg_rdata)
   );
endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk
   import ecc_log_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CHK_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wen,
   input logic [REG_AW-1:0] reg_addr,
   input logic [REG_DW-1:0] reg_wdata,
   input logic              ce_evt,
   input logic              ue_evt,
   input logic [ADDR_W-1:0] evt_addr,
   input logic              wr_req,
   input logic [CHK_W-1:0]  chk_xor,
   input logic              irq,
   input logic [1:0]        single,
   input logic [1:0]        dbl,
   input logic [ADDR_W-1:0] ce_log_addr,
   input logic              arm,
   input logic [1:0]        mode,
   input logic [CHK_W-1:0]  mask
);
   logic ack_w, opt_w;
   assign ack_w = reg_wen && (reg_addr == OFS_ACK);
   assign opt_w = reg_wen && (reg_addr == OFS_OPT);

   // R2: first correctable event fills the log
   a_r2_first_load: assert property (@(posedge clk) disable iff (!rst_n)
      ce_evt && !single[0] |=> single[0] && ce_log_addr == $past(evt_addr));

   // R4: repeat event sets overflow and keeps the log
   a_r4_keep_log: assert property (@(posedge clk) disable iff (!rst_n)
      ce_evt && single[0] |=> dbl[0] && $stable(ce_log_addr));

   // R5: acknowledge without a competing event clears the flag
   a_r5_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ack_w && reg_wdata[3] && !ce_evt |=> !single[0]);

   // R6: an event raises the interrupt; without writes it holds
   a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ue_evt |=> irq);
   a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !reg_wen |=> irq);

   // R7: event beats a same-cycle acknowledge
   a_r7_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ue_evt && ack_w && reg_wdata[5] |=> single[1]);

   // R10: arm drops after one write, mode and mask kept
   a_r10_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
      arm && wr_req && !opt_w |=> !arm && $stable(mode) && $stable(mask));
   a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |-> chk_xor == '0);
endmodule

bind ecc_err_logger ecc_err_logger_chk #(.ADDR_W(ADDR_W), .CHK_W(CHK_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wen    (reg_wen),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .ce_evt     (ce_evt),
   .ue_evt     (ue_evt),
   .evt_addr   (evt_addr),
   .wr_req     (wr_req),
   .chk_xor    (chk_xor),
   .irq        (irq),
   .single     (cls_single),
   .dbl        (cls_double),
   .ce_log_addr(cls_addr[0]),
   .arm        (opt_arm),
   .mode       (opt_mode),
   .mask       (opt_mask)
);

// File: tb/sim_ecc_err_logger.sv
`timescale 1ns/1ps
module sim_ecc_err_logger;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wen = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ce_evt = 1'b0, ue_evt = 1'b0;
   logic [31:0] evt_addr = '0;
   logic [63:0] evt_data = '0;
   logic [7:0]  evt_synd = '0;
   logic [15:0] evt_id = '0;
   logic        wr_req = 1'b0;
   logic [7:0]  chk_xor;
   logic        ecc_active, irq;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   ecc_err_logger u0 (
      .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ce_evt(ce_evt),
      .ue_evt(ue_evt), .evt_addr(evt_addr), .evt_data(evt_data),
      .evt_synd(evt_synd), .evt_id(evt_id), .wr_req(wr_req),
      .chk_xor(chk_xor), .ecc_active(ecc_active), .irq(irq)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic fire(input logic ce, input logic ue, input logic [31:0] a,
                       input logic [63:0] d, input logic [7:0] s, input logic [15:0] id);
      @(negedge clk);
      ce_evt = ce; ue_evt = ue; evt_addr = a; evt_data = d; evt_synd = s; evt_id = id;
      @(negedge clk);
      ce_evt = 1'b0; ue_evt = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(12'h180, v); chk("R1 status", v, 0);
      rd(12'h128, v); chk("R1 option", v, 32'h1);
      rd(12'h140, v); chk("R1 ce addr", v, 0);
      chk("R1 irq", irq, 0);
      chk("R11 active at reset", ecc_active, 1);
   endtask

   task automatic t_ce_first;
      logic [31:0] v;
      fire(1, 0, 32'h1234_5678, 64'hDEAD_BEEF_0BAD_F00D, 8'h5C, 16'h00A7);
      rd(12'h180, v); chk("R2 status", v, 32'h08);
      rd(12'h140, v); chk("R2 addr", v, 32'h1234_5678);
      rd(12'h144, v); chk("R2 syndrome word", v, 32'h0000_5C00);
      rd(12'h148, v); chk("R2 data lo", v, 32'h0BAD_F00D);
      rd(12'h14C, v); chk("R2 data hi", v, 32'hDEAD_BEEF);
      rd(12'h428, v); chk("R2 id", v, 32'h00A7);
      chk("R6 irq up", irq, 1);
      rd(12'h130, v); chk("R8 ue log untouched", v, 0);
   endtask

   task automatic t_ce_second;
      logic [31:0] v;
      fire(1, 0, 32'hAAAA_0000, 64'h1, 8'h11, 16'h0001);
      rd(12'h180, v); chk("R4 overflow bit", v, 32'h18);
      rd(12'h140, v); chk("R4 addr kept", v, 32'h1234_5678);
      rd(12'h144, v); chk("R4 syndrome kept", v, 32'h0000_5C00);
   endtask

   task automatic t_ack_partial;
      logic [31:0] v;
      wr(12'h184, 32'h08);
      rd(12'h180, v); chk("R5 only bit3 cleared", v, 32'h10);
      chk("R6 irq held by overflow", irq, 1);
      wr(12'h184, 32'h10);
      rd(12'h180, v); chk("R5 all clear", v, 0);
      chk("R6 irq down", irq, 0);
   endtask

   task automatic t_ue;
      logic [31:0] v;
      fire(0, 1, 32'h0000_F00C, 64'h0123_4567_89AB_CDEF, 8'hE1, 16'hBEEF);
      rd(12'h180, v); chk("R3 status", v, 32'h20);
      rd(12'h130, v); chk("R3 addr", v, 32'h0000_F00C);
      rd(12'h134, v); chk("R3 syndrome word", v, 32'h0000_E100);
      rd(12'h138, v); chk("R3 data lo", v, 32'h89AB_CDEF);
      rd(12'h13C, v); chk("R3 data hi", v, 32'h0123_4567);
      rd(12'h424, v); chk("R3 id", v, 32'hBEEF);
      rd(12'h140, v); chk("R8 ce log untouched", v, 32'h1234_5678);
      fire(0, 1, 32'h5, 64'h5, 8'h5, 16'h5);
      rd(12'h180, v); chk("R4 ue overflow", v, 32'h60);
      rd(12'h130, v); chk("R4 ue addr kept", v, 32'h0000_F00C);
      wr(12'h184, 32'h60);
   endtask

   task automatic t_collide;
      logic [31:0] v;
      fire(1, 0, 32'h0000_0C01, 64'h0, 8'h01, 16'h0);
      @(negedge clk);
      ce_evt = 1'b1; evt_addr = 32'h0000_0C02;
      reg_wen = 1'b1; reg_addr = 12'h184; reg_wdata = 32'h08;
      @(negedge clk);
      ce_evt = 1'b0; reg_wen = 1'b0;
      rd(12'h180, v); chk("R7 event beats ack", v, 32'h18);
      rd(12'h140, v); chk("R7 log kept", v, 32'h0000_0C01);
      wr(12'h184, 32'h7F);
   endtask

   task automatic t_both;
      logic [31:0] v;
      fire(1, 1, 32'h0B07_0B07, 64'h77, 8'h33, 16'h0042);
      rd(12'h180, v); chk("R8 both flags", v, 32'h28);
      rd(12'h140, v); chk("R8 ce addr", v, 32'h0B07_0B07);
      rd(12'h130, v); chk("R8 ue addr", v, 32'h0B07_0B07);
      wr(12'h184, 32'h28);
      rd(12'h180, v); chk("R5 cleared both", v, 0);
   endtask

   task automatic t_inject;
      logic [31:0] v;
      wr(12'h128, 32'hFFA5_F1FE);
      rd(12'h128, v); chk("R9 readback masks unused bits", v, 32'h00A5_0102);
      chk("R11 mode 2 off", ecc_active, 0);
      @(negedge clk); #1 chk("R10 no write no mask", chk_xor, 0);
      @(negedge clk); wr_req = 1'b1;
      #1 chk("R10 mask on armed write", chk_xor, 8'hA5);
      @(negedge clk); wr_req = 1'b0;
      rd(12'h128, v); chk("R10 disarmed, mode and mask kept", v, 32'h00A5_0002);
      @(negedge clk); wr_req = 1'b1;
      #1 chk("R10 next write clean", chk_xor, 0);
      @(negedge clk); wr_req = 1'b0;
      wr(12'h128, 32'h3);
      chk("R11 mode 3 on", ecc_active, 1);
      wr(12'h128, 32'h0);
      chk("R11 mode 0 off", ecc_active, 0);
   endtask

   initial begin
      #(10 * 100000);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_ce_first;
      t_ce_second;
      t_ack_partial;
      t_ue;
      t_collide;
      t_both;
      t_inject;
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule